// File: doc/BRIEF.md
# Bundle Write Commit Queue

This block holds the register writes and program-counter writes that the instructions of one wide issue bundle produce. Nothing is written while the bundle runs. A commit strobe then drains the held writes in a fixed way. Each held entry carries:

- the address of the instruction that produced it,
- a kind code,
- a target register index,
- a data value,
- a force flag.

During the drain, register-kind entries go out on a single register-file write port, one entry per cycle, in the order they arrived. For every entry it applies, the block shows that entry's instruction address on an output, so that a fault raised by the write can be charged to the right instruction. Of the program-counter entries, only the first one that is applied takes effect. The PC register inside the block takes its value when the drain finishes.

An imprecise exception can be recorded before commit. It is a faulting address, a floating-point flag and a status mask. Entries issued from that address are then filtered. A call-type instruction can ask for the link register to be loaded on commit. The block then emits a link write carrying the PC as it stood before the commit. A bundle-start pulse empties the queue, drops the recorded exception and drops the link request.

Top module: `bundle_commit_queue`

## Requirements
- R1: After reset, `pc_out` equals RESET_PC (default 16'h0100), and `busy`, `done`, `rf_we`, `link_we` and `overflow` are all 0.
- R2: A `commit` pulse taken while idle starts the drain. Entry k (counting from 0, in enqueue order) is presented in the (k+1)-th cycle after that pulse. For a register-kind entry (kind 0 or kind 3) that is not suppressed, `rf_we` is 1 in that cycle, with the entry's index on `rf_idx` and its value on `rf_data`. In every other cycle `rf_we` is 0.
- R3: In each drain cycle, `cur_addr` equals the instruction address of the entry being presented.
- R4: Kind 1 is a direct PC write and kind 2 is a computed PC write. The PC takes the value of the first applied entry of either kind. Later PC-kind entries in the same drain are skipped. `pc_out` changes only at the end of the `done` cycle. If no PC-kind entry was applied, `pc_out` keeps its pre-commit value.
- R5: The exception filter affects only entries whose instruction address equals the recorded faulting address. All other entries apply normally.
- R6: With a recorded floating-point exception, a matching entry is dropped if the mask has any bit set other than bit 0 (inexact), bit 1 (underflow) or bit 2 (overflow). Otherwise the entry is applied.
- R7: With a recorded exception that is not floating-point, a matching entry is applied only if its force flag is 1.
- R8: A dropped PC-kind entry does not use up the single PC update. A later applied PC-kind entry still sets the PC.
- R9: If `link_req` was seen since the last bundle start, the `done` cycle also has `link_we`=1, with `link_data` equal to the pre-commit PC. The request then clears, so the next commit makes no link write.
- R10: `done` is a one-cycle pulse, in the cycle after the last entry is presented. A commit of an empty queue pulses `done` in the cycle after `commit`. The queue is empty once the drain ends.
- R11: `bundle_start` empties the queue, discards the recorded exception and discards a pending link request.
- R12: An enqueue while DEPTH entries are already held is dropped and sets `overflow`. `overflow` stays 1 until reset, including across bundle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bundle_start | input | 1 | Starts a new bundle: clears queue, exception and link request |
| enq_valid | input | 1 | Enqueue strobe |
| enq_addr | input | AW | Address of the producing instruction |
| enq_kind | input | 2 | 0/3 register, 1 direct PC, 2 computed PC |
| enq_idx | input | IW | Target register index |
| enq_value | input | DW | Write value |
| enq_force | input | 1 | Force flag for non-floating-point exception filtering |
| exc_set | input | 1 | Records an imprecise exception |
| exc_addr | input | AW | Faulting instruction address |
| exc_is_fp | input | 1 | Exception is floating-point |
| exc_mask | input | FW | Floating-point status mask |
| link_req | input | 1 | Request link write on commit |
| commit | input | 1 | Starts the drain |
| busy | output | 1 | Drain or completion in progress |
| rf_we | output | 1 | Register-file write enable |
| rf_idx | output | IW | Register-file write index |
| rf_data | output | DW | Register-file write data |
| cur_addr | output | AW | Instruction address of the entry being applied |
| pc_out | output | AW | Program counter |
| link_we | output | 1 | Link register write enable |
| link_data | output | AW | Link register write value (pre-commit PC) |
| done | output | 1 | Drain complete pulse |
| overflow | output | 1 | Sticky enqueue-overflow flag |

## Verification
The assertions assume that the environment raises `enq_valid`, `exc_set`, `link_req`, `bundle_start` and `commit` only while `busy` is low. Under that assumption the PC can move only at the end of a `done` cycle, and register writes can appear only inside a drain. The bench keeps to the assumption: it drives all inputs on the falling edge, waits out each drain in full, and only then starts the next bundle. It reads each result one clock phase after the edge that produces it.

// File: rtl/bcq_pkg.sv
package bcq_pkg;

  localparam logic [1:0] KIND_REG   = 2'd0;
  localparam logic [1:0] KIND_PC    = 2'd1;
  localparam logic [1:0] KIND_PCFN  = 2'd2;
  localparam logic [1:0] KIND_REG_B = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRAIN = 2'd1,
    ST_DONE  = 2'd2
  } drain_state_e;

  function automatic logic kind_is_pc(input logic [1:0] kind);
    return (kind == KIND_PC) || (kind == KIND_PCFN);
  endfunction

  // Decide whether an entry survives the exception filter.
  function automatic logic entry_survives(input logic pending,
                                          input logic addr_hit,
                                          input logic is_fp,
                                          input logic fatal_bits,
                                          input logic force_flag);
    if (!(pending && addr_hit)) return 1'b1;
    if (is_fp) return !fatal_bits;
    return force_flag;
  endfunction

endpackage

// File: rtl/bcq_store.sv
module bcq_store #(
  parameter int DEPTH = 16,
  parameter int EW    = 40,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [EW-1:0] push_data,
  input  logic [PW-1:0] rd_idx,
  output logic [EW-1:0] rd_data,
  output logic [CW-1:0] count,
  output logic          ovf
);

  logic [EW-1:0] slot_q [DEPTH];
  logic          full;
  logic          accept;

  assign full   = (count == CW'(DEPTH));
  assign accept = push && !clr && !full;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               slot_q[g] <= '0;
        else if (accept && (count == CW'(g)))     slot_q[g] <= push_data;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (clr)    count <= '0;
    else if (accept) count <= count + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     ovf <= 1'b0;
    else if (push && !clr && full)  ovf <= 1'b1;
  end

  assign rd_data = slot_q[rd_idx];

  assert_count_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

endmodule

// File: rtl/bcq_filter.sv
module bcq_filter #(
  parameter int           AW       = 16,
  parameter int           FW       = 8,
  parameter logic [FW-1:0] TOL_MASK = 8'h07
) (
  input  logic          exc_pending,
  input  logic [AW-1:0] exc_addr,
  input  logic          exc_is_fp,
  input  logic [FW-1:0] exc_mask,
  input  logic [AW-1:0] ent_addr,
  input  logic          ent_force,
  output logic          keep
);
  import bcq_pkg::*;

  logic addr_hit;
  logic fatal_bits;

  assign addr_hit   = (ent_addr == exc_addr);
  assign fatal_bits = |(exc_mask & ~TOL_MASK);
  assign keep       = entry_survives(exc_pending, addr_hit, exc_is_fp,
                                     fatal_bits, ent_force);
endmodule

// File: rtl/bundle_commit_queue.sv
module bundle_commit_queue #(
  parameter int            AW       = 16,
  parameter int            DW       = 16,
  parameter int            IW       = 5,
  parameter int            FW       = 8,
  parameter int            DEPTH    = 16,
  parameter logic [AW-1:0] RESET_PC = 16'h0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bundle_start,
  input  logic          enq_valid,
  input  logic [AW-1:0] enq_addr,
  input  logic [1:0]    enq_kind,
  input  logic [IW-1:0] enq_idx,
  input  logic [DW-1:0] enq_value,
  input  logic          enq_force,
  input  logic          exc_set,
  input  logic [AW-1:0] exc_addr,
  input  logic          exc_is_fp,
  input  logic [FW-1:0] exc_mask,
  input  logic          link_req,
  input  logic          commit,
  output logic          busy,
  output logic          rf_we,
  output logic [IW-1:0] rf_idx,
  output logic [DW-1:0] rf_data,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] pc_out,
  output logic          link_we,
  output logic [AW-1:0] link_data,
  output logic          done,
  output logic          overflow
);
  import bcq_pkg::*;

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = PW + 1;
  localparam int EW = AW + 2 + IW + DW + 1;
  localparam logic [FW-1:0] TOL_MASK = FW'(3'b111);

  drain_state_e  state_q;
  logic [PW-1:0] rd_ptr_q;
  logic [CW-1:0] count;
  logic [EW-1:0] head;
  logic          pc_taken_q;
  logic [AW-1:0] pc_next_q;
  logic [AW-1:0] pc_q;
  logic          link_flag_q;
  logic          exc_pending_q;
  logic [AW-1:0] exc_addr_q;
  logic          exc_fp_q;
  logic [FW-1:0] exc_mask_q;

  // Named internal events
  logic          idle;
  logic          draining;
  logic          push_ok;
  logic          clear_queue;
  logic          ent_keep;
  logic          ent_is_pc;
  logic          apply_pc;
  logic          last_entry;

  logic [AW-1:0] ent_addr;
  logic [1:0]    ent_kind;
  logic [IW-1:0] ent_idx;
  logic [DW-1:0] ent_value;
  logic          ent_force;

  assign idle        = (state_q == ST_IDLE);
  assign draining    = (state_q == ST_DRAIN);
  assign push_ok     = enq_valid && idle;
  assign clear_queue = bundle_start || (state_q == ST_DONE);

  bcq_store #(.DEPTH(DEPTH), .EW(EW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clear_queue),
    .push      (push_ok),
    .push_data ({enq_addr, enq_kind, enq_idx, enq_value, enq_force}),
    .rd_idx    (rd_ptr_q),
    .rd_data   (head),
    .count     (count),
    .ovf       (overflow)
  );

  assign {ent_addr, ent_kind, ent_idx, ent_value, ent_force} = head;

  bcq_filter #(.AW(AW), .FW(FW), .TOL_MASK(TOL_MASK)) u_filter (
    .exc_pending (exc_pending_q),
    .exc_addr    (exc_addr_q),
    .exc_is_fp   (exc_fp_q),
    .exc_mask    (exc_mask_q),
    .ent_addr    (ent_addr),
    .ent_force   (ent_force),
    .keep        (ent_keep)
  );

  assign ent_is_pc  = kind_is_pc(ent_kind);
  assign apply_pc   = draining && ent_keep && ent_is_pc && !pc_taken_q;
  assign last_entry = (CW'(rd_ptr_q) + CW'(1)) == count;

  assign busy      = !idle;
  assign rf_we     = draining && ent_keep && !ent_is_pc;
  assign rf_idx    = ent_idx;
  assign rf_data   = ent_value;
  assign cur_addr  = draining ? ent_addr : '0;
  assign done      = (state_q == ST_DONE);
  assign link_we   = done && link_flag_q;
  assign link_data = pc_q;
  assign pc_out    = pc_q;

  // Drain sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      rd_ptr_q   <= '0;
      pc_taken_q <= 1'b0;
      pc_next_q  <= '0;
      pc_q       <= RESET_PC;
    end else begin
      unique case (state_q)
        ST_IDLE: if (commit) begin
          rd_ptr_q   <= '0;
          pc_taken_q <= 1'b0;
          state_q    <= (count == '0) ? ST_DONE : ST_DRAIN;
        end
        ST_DRAIN: begin
          if (apply_pc) begin
            pc_taken_q <= 1'b1;
            pc_next_q  <= AW'(ent_value);
          end
          if (last_entry) state_q  <= ST_DONE;
          else            rd_ptr_q <= rd_ptr_q + PW'(1);
        end
        ST_DONE: begin
          if (pc_taken_q) pc_q <= pc_next_q;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Bundle context: exception descriptor and link request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_flag_q   <= 1'b0;
      exc_pending_q <= 1'b0;
      exc_addr_q    <= '0;
      exc_fp_q      <= 1'b0;
      exc_mask_q    <= '0;
    end else if (bundle_start) begin
      link_flag_q   <= 1'b0;
      exc_pending_q <= 1'b0;
    end else begin
      if (done)          link_flag_q <= 1'b0;
      else if (link_req) link_flag_q <= 1'b1;
      if (exc_set) begin
        exc_pending_q <= 1'b1;
        exc_addr_q    <= exc_addr;
        exc_fp_q      <= exc_is_fp;
        exc_mask_q    <= exc_mask;
      end
    end
  end

  assert_we_in_drain_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> busy);

  assert_pc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(pc_out));

  assert_link_on_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> done);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_ovf_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

endmodule

// File: tb/bundle_commit_queue_test.sv
module bundle_commit_queue_test;

  localparam int DEPTH = 16;
  localparam logic [15:0] RST_PC = 16'h0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bundle_start = 0, enq_valid = 0, enq_force = 0;
  logic [15:0] enq_addr = 0, enq_value = 0, exc_addr = 0;
  logic [1:0]  enq_kind = 0;
  logic [4:0]  enq_idx = 0;
  logic        exc_set = 0, exc_is_fp = 0, link_req = 0, commit = 0;
  logic [7:0]  exc_mask = 0;
  logic        busy, rf_we, link_we, done, overflow;
  logic [4:0]  rf_idx;
  logic [15:0] rf_data, cur_addr, pc_out, link_data;

  always #10 clk = ~clk;

  bundle_commit_queue uut (
    .clk(clk), .rst_n(rst_n), .bundle_start(bundle_start),
    .enq_valid(enq_valid), .enq_addr(enq_addr), .enq_kind(enq_kind),
    .enq_idx(enq_idx), .enq_value(enq_value), .enq_force(enq_force),
    .exc_set(exc_set), .exc_addr(exc_addr), .exc_is_fp(exc_is_fp),
    .exc_mask(exc_mask), .link_req(link_req), .commit(commit),
    .busy(busy), .rf_we(rf_we), .rf_idx(rf_idx), .rf_data(rf_data),
    .cur_addr(cur_addr), .pc_out(pc_out), .link_we(link_we),
    .link_data(link_data), .done(done), .overflow(overflow)
  );

  int checks = 0;
  int errors = 0;

  // Bench-side model of the queue
  logic [15:0] m_addr [0:31];
  logic [1:0]  m_kind [0:31];
  logic [4:0]  m_idx  [0:31];
  logic [15:0] m_val  [0:31];
  logic        m_frc  [0:31];
  int          m_n = 0;
  logic        m_exc = 0, m_fp = 0, m_link = 0;
  logic [15:0] m_exc_addr = 0;
  logic [7:0]  m_mask = 0;
  logic [15:0] m_pc = RST_PC;

  // {addr, kind, idx, value, force}
  localparam logic [39:0] VEC [0:7] = '{
    {16'h0200, 2'd0, 5'd1,  16'h1111, 1'b0},
    {16'h0204, 2'd0, 5'd2,  16'h2222, 1'b0},
    {16'h0208, 2'd1, 5'd0,  16'h0400, 1'b0},
    {16'h020c, 2'd3, 5'd3,  16'h3333, 1'b0},
    {16'h0210, 2'd2, 5'd0,  16'h0500, 1'b0},
    {16'h0214, 2'd0, 5'd31, 16'hffff, 1'b1},
    {16'h0218, 2'd1, 5'd0,  16'h0600, 1'b0},
    {16'h021c, 2'd0, 5'd0,  16'h0001, 1'b0}
  };

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start_bundle();
    bundle_start = 1'b1;
    @(negedge clk);
    bundle_start = 1'b0;
    m_n = 0; m_exc = 0; m_link = 0;
  endtask

  task automatic push(input logic [15:0] a, input logic [1:0] k,
                      input logic [4:0] i, input logic [15:0] v, input logic f);
    enq_valid = 1; enq_addr = a; enq_kind = k; enq_idx = i;
    enq_value = v; enq_force = f;
    @(negedge clk);
    enq_valid = 0;
    if (m_n < DEPTH) begin
      m_addr[m_n] = a; m_kind[m_n] = k; m_idx[m_n] = i;
      m_val[m_n] = v;  m_frc[m_n] = f;  m_n++;
    end
  endtask

  task automatic raise_exc(input logic [15:0] a, input logic fp,
                           input logic [7:0] mask);
    exc_set = 1; exc_addr = a; exc_is_fp = fp; exc_mask = mask;
    @(negedge clk);
    exc_set = 0;
    m_exc = 1; m_exc_addr = a; m_fp = fp; m_mask = mask;
  endtask

  task automatic ask_link();
    link_req = 1;
    @(negedge clk);
    link_req = 0;
    m_link = 1;
  endtask

  // Commit and check every drain cycle against the bench model.
  task automatic commit_check(input string tag);
    logic taken = 0;
    logic [15:0] newpc = m_pc;
    commit = 1;
    @(negedge clk);
    commit = 0;
    for (int i = 0; i < m_n; i++) begin
      logic hit, keep, ispc, we;
      hit  = m_exc && (m_addr[i] == m_exc_addr);
      keep = !hit || (m_fp ? ((m_mask & 8'hf8) == 0) : m_frc[i]);
      ispc = (m_kind[i] == 2'd1) || (m_kind[i] == 2'd2);
      we   = keep && !ispc;
      if (keep && ispc && !taken) begin taken = 1; newpc = m_val[i]; end
      chk(rf_we == we && (!we || (rf_idx == m_idx[i] && rf_data == m_val[i])),
          {tag, " R2 write"}, {rf_we, 10'd0, rf_idx, rf_data},
          {we, 10'd0, m_idx[i], m_val[i]});
      chk(cur_addr == m_addr[i], {tag, " R3 addr"}, cur_addr, m_addr[i]);
      chk(done == 0, {tag, " R10 early done"}, done, 0);
      @(negedge clk);
    end
    chk(done == 1 && rf_we == 0, {tag, " R10 done"}, {done, rf_we}, 2'b10);
    chk(link_we == m_link && (!m_link || link_data == m_pc),
        {tag, " R9 link"}, {link_we, link_data}, {m_link, m_pc});
    @(negedge clk);
    m_pc = newpc;
    m_link = 0;
    m_n = 0;
    chk(pc_out == m_pc, {tag, " R4 pc"}, pc_out, m_pc);
    chk(busy == 0 && done == 0, {tag, " R10 idle"}, {busy, done}, 0);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(pc_out == RST_PC, "R1 pc", pc_out, RST_PC);
    chk({busy, done, rf_we, link_we, overflow} == 0, "R1 flags",
        {busy, done, rf_we, link_we, overflow}, 0);
    rst_n = 1;
    @(negedge clk);

    // Vector table: mixed kinds, several PC entries, link request
    start_bundle();
    for (int v = 0; v < 8; v++)
      push(VEC[v][39:24], VEC[v][23:22], VEC[v][21:17], VEC[v][16:1], VEC[v][0]);
    ask_link();
    commit_check("table");
    chk(pc_out == 16'h0400, "R4 first pc wins", pc_out, 16'h0400);

    // R9: link request cleared after use; R4: no PC entry keeps pc
    start_bundle();
    push(16'h0400, 2'd0, 5'd4, 16'h4444, 0);
    push(16'h0404, 2'd3, 5'd5, 16'h5555, 0);
    commit_check("nopc");
    chk(pc_out == 16'h0400, "R4 pc kept", pc_out, 16'h0400);

    // R5 R6 R8: fp exception, tolerated mask -> written
    start_bundle();
    push(16'h0500, 2'd0, 5'd6, 16'h6666, 0);
    push(16'h0504, 2'd0, 5'd7, 16'h7777, 0);
    raise_exc(16'h0500, 1, 8'h05);
    commit_check("fp_tol");

    // R6 R8: fp exception, fatal mask -> entries from fault address dropped
    start_bundle();
    push(16'h0600, 2'd0, 5'd8, 16'h8888, 1);
    push(16'h0600, 2'd1, 5'd0, 16'h0700, 0);
    push(16'h0604, 2'd0, 5'd9, 16'h9999, 0);
    push(16'h0608, 2'd2, 5'd0, 16'h0800, 0);
    raise_exc(16'h0600, 1, 8'h10);
    commit_check("fp_fatal");
    chk(pc_out == 16'h0800, "R8 later pc used", pc_out, 16'h0800);

    // R7: non-fp exception, force flag decides
    start_bundle();
    push(16'h0700, 2'd0, 5'd10, 16'haaaa, 0);
    push(16'h0700, 2'd0, 5'd11, 16'hbbbb, 1);
    push(16'h0704, 2'd0, 5'd12, 16'hcccc, 0);
    raise_exc(16'h0700, 0, 8'hff);
    ask_link();
    commit_check("force");

    // R10: empty commit
    start_bundle();
    commit_check("empty");

    // R11: bundle_start discards queue, exception and link request
    start_bundle();
    push(16'h0800, 2'd0, 5'd13, 16'hdddd, 0);
    push(16'h0804, 2'd1, 5'd0, 16'h0900, 0);
    raise_exc(16'h0900, 0, 8'h00);
    ask_link();
    start_bundle();
    push(16'h0900, 2'd0, 5'd14, 16'heeee, 0);
    commit_check("restart");
    chk(pc_out == 16'h0800, "R11 stale pc ignored", pc_out, 16'h0800);

    // R12: overflow
    start_bundle();
    chk(overflow == 0, "R12 no overflow yet", overflow, 0);
    for (int i = 0; i < DEPTH; i++)
      push(16'h1000 + 16'(i), 2'd0, 5'(i), 16'h0100 + 16'(i), 0);
    chk(overflow == 0, "R12 full no overflow", overflow, 0);
    push(16'h2000, 2'd0, 5'd30, 16'hdead, 0);
    chk(overflow == 1, "R12 overflow set", overflow, 1);
    commit_check("ovf");
    start_bundle();
    chk(overflow == 1, "R12 overflow sticky", overflow, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule